// File: doc/BRIEF.md
# Timer Capture Channel with Selectable Commit Timing

One capture channel that sits beside a free-running timer counter. The channel watches an external capture pin and, on a chosen edge, stores the counter value in a capture register and raises a capture flag. A capture that arrives while the flag is still set also raises an overflow flag. The pin is first passed through a two-flop synchronizer to the system clock. Edge detection then works on the synchronized level.

A mode bit selects when a detected edge takes effect. In immediate mode the capture is committed in the same cycle that the edge is detected, even when the timer is stopped. In tick-aligned mode the edge is held as pending. It is committed on the first system-clock cycle in which the timer is running and its tick enable is high, and the counter value of that cycle is stored. Further edges that arrive while an event is pending are merged into it. For this reason tick-aligned mode can miss an overflow that immediate mode would report.

Software sets the edge select and the mode through a control write strobe. Writing all zeros to the control fields also clears both flags and any pending event. Separate strobes clear the capture flag and the overflow flag.

Top module: `cap_channel`

## Requirements
- R1: After reset, cap_flag and ovf_flag are 0 and cap_val is 0.
- R2: The active edges are selected by edge_q, which is loaded from cfg_edge on cfg_wr: 00 none, 01 rising, 10 falling, 11 both. An edge on cap_in is detected three clock edges after cap_in changes (two synchronizer flops and one history flop). A transition that is not selected has no effect on cap_flag or cap_val.
- R3: In immediate mode (sync bit 0), a detected edge commits at once, whether or not the timer runs. On that clock edge cap_flag becomes 1 and cap_val takes the count present in the detection cycle.
- R4: In tick-aligned mode (sync bit 1), a detected edge in a cycle without run and tick both high leaves cap_flag and cap_val unchanged and marks the event pending. A tick while run is 0 does not commit.
- R5: In tick-aligned mode, the first cycle with run=1 and tick=1 that has a pending or same-cycle detected edge commits it. cap_flag is set and cap_val takes the count of that cycle.
- R6: A commit while cap_flag is 1 and flag_clr is not asserted sets ovf_flag.
- R7: In tick-aligned mode, several edges detected before a commit tick count as one event. They set neither ovf_flag nor a second capture.
- R8: flag_clr clears cap_flag and leaves ovf_flag unchanged. ovf_clr clears ovf_flag and leaves cap_flag unchanged.
- R9: When a commit and flag_clr occur in the same cycle, cap_flag stays 1, cap_val is updated, and ovf_flag is not set by that commit.
- R10: A control write with cfg_edge=00 and cfg_sync=0 clears cap_flag, ovf_flag and any pending event. It has priority over a commit in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Timer tick enable, one cycle per timer count |
| run | input | 1 | Timer running (1) or stopped (0) |
| count | input | CW | Current timer counter value |
| cap_in | input | 1 | External capture pin, asynchronous |
| cfg_edge | input | 2 | Edge select value for a control write |
| cfg_sync | input | 1 | Mode value for a control write: 1 tick-aligned, 0 immediate |
| cfg_wr | input | 1 | Control write strobe |
| flag_clr | input | 1 | Capture flag clear strobe |
| ovf_clr | input | 1 | Overflow flag clear strobe |
| cap_val | output | CW | Captured counter value |
| cap_flag | output | 1 | Capture flag |
| ovf_flag | output | 1 | Overflow flag |

## Verification
The bench builds the channel with an 8-bit counter. This keeps every captured value easy to tell apart by eye, and the timing behaviour is the same at any width. It sweeps all four edge selections, both modes and both pin transition directions. In each case it checks the state with the timer stopped, and then the state after a single running tick with a new count. This separates an immediate capture of the old count from a tick-aligned capture of the new count. Targeted sequences then cover merged edges, slow edges that overflow, each clear strobe alone, a clear that collides with a commit, and a pending event discarded by a zero control write.

// File: rtl/cap_channel.sv
module cap_channel #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          run,
  input  logic [CW-1:0] count,
  input  logic          cap_in,
  input  logic [1:0]    cfg_edge,
  input  logic          cfg_sync,
  input  logic          cfg_wr,
  input  logic          flag_clr,
  input  logic          ovf_clr,
  output logic [CW-1:0] cap_val,
  output logic          cap_flag,
  output logic          ovf_flag
);
  logic [2:0] sy;
  logic [1:0] edge_q;
  logic       sync_q, pend;
  logic       rise, fall, hit, commit, cfg_zero;

  assign rise     = sy[1] & ~sy[2];
  assign fall     = ~sy[1] & sy[2];
  assign hit      = (edge_q[0] & rise) | (edge_q[1] & fall);
  assign commit   = sync_q ? (tick & run & (pend | hit)) : hit;
  assign cfg_zero = cfg_wr & (cfg_edge == 2'b00) & ~cfg_sync;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sy <= '0;
    else        sy <= {sy[1:0], cap_in};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      edge_q <= 2'b00;
      sync_q <= 1'b0;
    end else if (cfg_wr) begin
      edge_q <= cfg_edge;
      sync_q <= cfg_sync;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                 pend <= 1'b0;
    else if (cfg_zero)          pend <= 1'b0;
    else if (sync_q && commit)  pend <= 1'b0;
    else if (sync_q && hit)     pend <= 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       cap_val <= '0;
    else if (commit)  cap_val <= count;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                  cap_flag <= 1'b0;
    else if (cfg_zero)           cap_flag <= 1'b0;
    else if (commit)             cap_flag <= 1'b1;
    else if (flag_clr)           cap_flag <= 1'b0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                                ovf_flag <= 1'b0;
    else if (cfg_zero)                         ovf_flag <= 1'b0;
    else if (commit && cap_flag && !flag_clr)  ovf_flag <= 1'b1;
    else if (ovf_clr)                          ovf_flag <= 1'b0;
endmodule

// File: rtl/cap_channel_chk.sv
module cap_channel_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick,
  input logic          run,
  input logic          cfg_wr,
  input logic [1:0]    cfg_edge,
  input logic          cfg_sync,
  input logic          flag_clr,
  input logic          ovf_clr,
  input logic          sync_q,
  input logic [CW-1:0] cap_val,
  input logic          cap_flag,
  input logic          ovf_flag
);
  logic zero_wr;
  assign zero_wr = cfg_wr && cfg_edge == 2'b00 && !cfg_sync;

  assert_tick_commit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cap_flag) && $past(sync_q)) |-> $past(tick && run));

  assert_zero_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    zero_wr |=> (!cap_flag && !ovf_flag));

  assert_ovf_needs_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_flag) |-> $past(cap_flag));

  assert_val_with_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(cap_val) && !$past(zero_wr)) |-> cap_flag);

  assert_flag_clr_keeps_ovf_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !ovf_clr && !cfg_wr && ovf_flag) |=> ovf_flag);
endmodule

bind cap_channel cap_channel_chk #(.CW(CW)) chk_i (
  .clk(clk), .rst_n(rst_n), .tick(tick), .run(run), .cfg_wr(cfg_wr),
  .cfg_edge(cfg_edge), .cfg_sync(cfg_sync), .flag_clr(flag_clr),
  .ovf_clr(ovf_clr), .sync_q(sync_q), .cap_val(cap_val),
  .cap_flag(cap_flag), .ovf_flag(ovf_flag)
);

// File: tb/cap_channel_tb_top.sv
`timescale 1ns/1ps
module cap_channel_tb_top;
  localparam int CW = 8;
  logic clk = 0, rst_n = 0;
  logic tick = 0, run = 0, cap_in = 0, cfg_sync = 0, cfg_wr = 0, flag_clr = 0, ovf_clr = 0;
  logic [1:0] cfg_edge = 0;
  logic [CW-1:0] count = 0;
  logic [CW-1:0] cap_val;
  logic cap_flag, ovf_flag;
  int nchk = 0, nfail = 0;
  logic [CW-1:0] mval;

  always #4 clk = ~clk;

  cap_channel #(.CW(CW)) dut_i (.*);

  task automatic chk(string req, int got, int exp);
    nchk++;
    if (got != exp) begin
      nfail++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic cyc(int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic cfg(logic [1:0] e, logic s);
    cfg_edge = e; cfg_sync = s; cfg_wr = 1; cyc(1); cfg_wr = 0;
  endtask

  task automatic tick1(logic [CW-1:0] c);
    count = c; tick = 1; run = 1; cyc(1); tick = 0; run = 0;
  endtask

  task automatic fin;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  endtask

  initial begin
    cyc(150000);
    nfail++;
    fin();
  end

  initial begin
    cyc(2);
    chk("R1 flag", cap_flag, 0); chk("R1 ovf", ovf_flag, 0); chk("R1 val", cap_val, 0);
    rst_n = 1; cyc(2);
    mval = 0;
    for (int i = 0; i < 16; i++) begin
      logic [1:0] es; logic sm, dr, m; logic [CW-1:0] c1, c2;
      es = i[1:0]; sm = i[2]; dr = i[3];
      c1 = CW'(8'h21 + i * 11); c2 = ~c1;
      m = (es[0] && !dr) || (es[1] && dr);
      cfg(2'b00, 0);
      cap_in = dr; cyc(4);
      cfg(es, sm);
      count = c1; cap_in = ~dr; cyc(4);
      if (m && !sm) mval = c1;
      chk("R2 R3 R4 stopped flag", cap_flag, m && !sm);
      chk("R2 R3 R4 stopped val", cap_val, mval);
      tick1(c2);
      if (m && sm) mval = c2;
      chk("R2 R5 ticked flag", cap_flag, m);
      chk("R2 R5 ticked val", cap_val, mval);
      chk("R7 sweep ovf", ovf_flag, 0);
    end
    // R4: tick without run does not commit
    cfg(2'b00, 0); cap_in = 0; cyc(4);
    cfg(2'b01, 1); count = 8'h3c; cap_in = 1; cyc(4);
    tick = 1; cyc(1); tick = 0;
    chk("R4 tick without run", cap_flag, 0);
    tick1(8'h5a);
    chk("R5 pending commit flag", cap_flag, 1); chk("R5 pending val", cap_val, 8'h5a);
    // R7: merged edges in tick-aligned mode
    cfg(2'b00, 0); cap_in = 0; cyc(4);
    cfg(2'b11, 1); cap_in = 1; cyc(4); cap_in = 0; cyc(4); cap_in = 1; cyc(4);
    tick1(8'h77);
    chk("R7 merged flag", cap_flag, 1); chk("R7 merged ovf", ovf_flag, 0);
    chk("R7 merged val", cap_val, 8'h77);
    // R6: slow edges in tick-aligned mode overflow
    cap_in = 0; cyc(4); tick1(8'h78);
    chk("R6 sync overflow", ovf_flag, 1); chk("R6 sync val", cap_val, 8'h78);
    // R8: separate clears
    flag_clr = 1; cyc(1); flag_clr = 0;
    chk("R8 flag cleared", cap_flag, 0); chk("R8 ovf kept", ovf_flag, 1);
    tick1(8'h01); cap_in = 1; cyc(4); tick1(8'h02);
    ovf_clr = 1; cyc(1); ovf_clr = 0;
    chk("R8 ovf cleared", ovf_flag, 0); chk("R8 flag kept", cap_flag, 1);
    // R6: fast edges in immediate mode overflow
    cfg(2'b00, 0); cap_in = 0; cyc(4);
    cfg(2'b11, 0); count = 8'h90; cap_in = 1; cyc(4); count = 8'h91; cap_in = 0; cyc(4);
    chk("R6 async overflow", ovf_flag, 1); chk("R6 async val", cap_val, 8'h91);
    // R9: clear collides with commit
    ovf_clr = 1; cyc(1); ovf_clr = 0;
    count = 8'hab; cap_in = 1; cyc(2); flag_clr = 1; cyc(1); flag_clr = 0;
    chk("R9 flag stays", cap_flag, 1); chk("R9 no ovf", ovf_flag, 0);
    chk("R9 val", cap_val, 8'hab);
    // R10: zero write drops pending event
    cfg(2'b00, 0); cap_in = 0; cyc(4);
    cfg(2'b01, 1); cap_in = 1; cyc(4);
    cfg(2'b00, 0); cfg(2'b01, 1);
    tick1(8'hcd);
    chk("R10 pending dropped", cap_flag, 0); chk("R10 val kept", cap_val, 8'hab);
    fin();
  end
endmodule